// File: doc/BRIEF.md
# Card Socket Power Sequencer

This block steps a removable-card socket from a powered-off state to a configured, ready state, and steps it back down when asked. A start command first cuts all socket supplies and the card reset pin, then waits for the supply to fall. It then brings up main power alone, waits for the supply to rise and settle, and after that enables the interface drivers and the programming supply. It pulses card reset, waits for the card to settle, and then polls the card's ready line at a fixed interval. Once the card reports ready, the interface is configured for an I/O card or a memory card, depending on a flag supplied by the host.

The polling loop ends in one of three ways. If neither card-detect sensor is active at a poll, the sequence aborts; this covers a card pulled out mid-sequence. If the card never reports ready within the poll budget, the sequence ends with a timeout. Otherwise it completes. A stop command first clears the interface configuration, one cycle later removes all power, and waits for the supply to fall before it reports completion.

Every wait is given in microseconds. Each wait is turned into clock cycles from a clock-frequency parameter, so an integration can shrink all of them for simulation.

Top module: `socket_pwr_seq`

## Requirements
- R1: While reset is high, and in the cycle after it, every socket drive output is low. This covers `main_pwr`, `vpp_on`, `if_oe`, `card_rst`, `io_irq_en` and `spkr_en`. In addition `if_type` is 2'b00, `enabling` is low and no outcome pulse is present.
- R2: A start command (`en_cmd`) accepted while the block is idle or ready does the following in the next cycle: it drives `main_pwr`, `vpp_on`, `if_oe` and `card_rst` low, clears the configuration (`if_type`=2'b00, `io_irq_en`=0, `spkr_en`=0) and raises `enabling`. It then holds this state for T_OFF_US.
- R3: After T_OFF_US, `main_pwr` rises alone and stays the only supply for T_ON_US.
- R4: After T_ON_US, `if_oe`, `vpp_on` and `card_rst` rise together. `card_rst` is held for T_RST_US and then released, and the first ready poll follows T_SETTLE_US later. `card_rst` is never high without `main_pwr`, `vpp_on` and `if_oe`.
- R5: `card_ready` is sampled at each poll, with polls T_POLL_US apart. The first poll that sees it high ends the sequence with a one-cycle `seq_done` pulse.
- R6: If MAX_POLLS polls pass without seeing ready, a one-cycle `seq_timeout` pulse ends the sequence and the supplies stay on.
- R7: A poll at which `cd_sense` is 2'b00 ends the sequence at once with a one-cycle `seq_abort` pulse, whatever the state of `card_ready`. A single active sensor counts as a card that is present.
- R8: On success with `card_is_io`=1 the block sets `if_type`=2'b10, `io_irq_en`=1 and `spkr_en`=1. With `card_is_io`=0 it sets `if_type`=2'b01, `io_irq_en`=0 and `spkr_en`=0. `io_irq_en` is only ever high with `main_pwr`, `if_oe` and the I/O type.
- R9: `enabling` stays high from the accepted start command until the cycle of the outcome pulse, and is low from that cycle on. At most one of `seq_done`, `seq_abort` and `seq_timeout` is high in any cycle.
- R10: Both `en_cmd` and `dis_cmd` are ignored while a start sequence or a power-down is in progress. Such a command neither restarts nor shortens the sequence, and it does not remove power.
- R11: An accepted stop command (`dis_cmd`) has two steps. In the next cycle it clears `if_type` to 2'b00, `io_irq_en` and `spkr_en` while power is still on. One cycle later it drops `main_pwr`, `vpp_on`, `if_oe` and `card_rst`. After T_DOWN_US it gives a `seq_done` pulse.
- R12: When `en_cmd` and `dis_cmd` arrive in the same cycle while the block is idle or ready, the stop command wins and `enabling` stays low.
- R13: A wait of N microseconds lasts N·CLK_FREQ_HZ/1e6 clock cycles, plus at most two cycles of phase overhead for each phase on the way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_cmd | input | 1 | Start power-up sequence (one-cycle command) |
| dis_cmd | input | 1 | Start power-down sequence (one-cycle command) |
| cd_sense | input | 2 | Card-detect sensors, 1 = card sensed |
| card_ready | input | 1 | Card ready line, 1 = ready |
| card_is_io | input | 1 | 1 = configure as I/O card, 0 = memory card |
| main_pwr | output | 1 | Main socket supply on |
| vpp_on | output | 1 | Programming supply routed to the supply level |
| if_oe | output | 1 | Interface output drivers enabled |
| card_rst | output | 1 | Card reset pin |
| if_type | output | 2 | Interface type: 00 none, 01 memory, 10 I/O |
| io_irq_en | output | 1 | Card I/O interrupt enabled |
| spkr_en | output | 1 | Card speaker output enabled |
| enabling | output | 1 | Start sequence in progress |
| seq_done | output | 1 | One-cycle pulse: power-up or power-down complete |
| seq_abort | output | 1 | One-cycle pulse: card absent at a poll |
| seq_timeout | output | 1 | One-cycle pulse: card never became ready |

## Verification
The bench sets CLK_FREQ_HZ to 4 MHz, so one microsecond lasts four cycles. It shrinks the waits to T_OFF_US=40, T_ON_US=32, T_RST_US=2, T_SETTLE_US=10, T_POLL_US=5 and T_DOWN_US=30, and it sets MAX_POLLS to 4. With these values a full power-up takes a few hundred cycles. Every phase edge can then be timed against its nominal duration, a ready line that rises between two polls can be pinned to the poll that sees it, and the timeout after the last poll comes within reach. The default values give waits of several hundred milliseconds and could not be run in a bench of this length.

// File: rtl/sockseq_pkg.sv
package sockseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_OFF_WAIT,
    S_PWR_WAIT,
    S_RST_HOLD,
    S_SETTLE,
    S_POLL,
    S_POLL_WAIT,
    S_READY,
    S_CFG_CLR,
    S_DOWN_WAIT
  } seq_state_t;

  typedef enum logic [1:0] {
    IFT_NONE = 2'b00,
    IFT_MEM  = 2'b01,
    IFT_IO   = 2'b10
  } iftype_t;

  typedef struct packed {
    logic    pwr;
    logic    vpp;
    logic    oe;
    logic    rst;
    iftype_t ift;
    logic    irq_en;
    logic    spkr;
  } sock_drive_t;

  localparam sock_drive_t DRIVE_OFF = '{pwr: 1'b0, vpp: 1'b0, oe: 1'b0, rst: 1'b0,
                                        ift: IFT_NONE, irq_en: 1'b0, spkr: 1'b0};

endpackage

// File: rtl/sockseq_timer.sv
// Loadable microsecond down-counter. A load restarts the prescaler, so a
// load of N expires exactly N*CYC_PER_US cycles later with a one-cycle pulse.
module sockseq_timer #(
  parameter int CYC_PER_US = 50,
  parameter int US_W       = 21
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [US_W-1:0] load_us,
  output logic            expired
);

  logic            running;
  logic [US_W-1:0] us_left;
  logic            us_tick;

  generate
    if (CYC_PER_US > 1) begin : g_prescale
      localparam int PRE_W = $clog2(CYC_PER_US);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);
      logic [PRE_W-1:0] pre;

      always_ff @(posedge clk) begin
        if (rst || load) begin
          pre <= '0;
        end else if (running) begin
          pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
        end
      end

      assign us_tick = running && (pre == PRE_LAST);
    end else begin : g_direct
      assign us_tick = running;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      us_left <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (load) begin
        us_left <= load_us;
        running <= (load_us != '0);
        if (load_us == '0) begin
          expired <= 1'b1;
        end
      end else if (us_tick) begin
        if (us_left == US_W'(1)) begin
          us_left <= '0;
          running <= 1'b0;
          expired <= 1'b1;
        end else begin
          us_left <= us_left - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sockseq_ctrl.sv
// Sequencing state machine with registered socket drives and outcome pulses.
module sockseq_ctrl
  import sockseq_pkg::*;
#(
  parameter int T_OFF_US    = 400000,
  parameter int T_ON_US     = 320000,
  parameter int T_RST_US    = 20,
  parameter int T_SETTLE_US = 20000,
  parameter int T_POLL_US   = 500,
  parameter int T_DOWN_US   = 300000,
  parameter int MAX_POLLS   = 10000,
  parameter int US_W        = 21,
  parameter int PC_W        = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_cmd,
  input  logic            dis_cmd,
  input  logic [1:0]      cd_sense,
  input  logic            card_ready,
  input  logic            card_is_io,
  input  logic            tmr_exp,
  output logic            tmr_load,
  output logic [US_W-1:0] tmr_us,
  output sock_drive_t     drv,
  output logic            enabling,
  output logic            seq_done,
  output logic            seq_abort,
  output logic            seq_timeout
);

  localparam logic [PC_W-1:0] POLL_LAST = PC_W'(MAX_POLLS - 1);

  seq_state_t      state_q, state_d;
  sock_drive_t     drv_d;
  logic [PC_W-1:0] poll_q, poll_d;
  logic            enab_d, done_d, abort_d, tmo_d;

  always_comb begin
    state_d  = state_q;
    drv_d    = drv;
    poll_d   = poll_q;
    enab_d   = enabling;
    done_d   = 1'b0;
    abort_d  = 1'b0;
    tmo_d    = 1'b0;
    tmr_load = 1'b0;
    tmr_us   = '0;

    unique case (state_q)
      S_IDLE, S_READY: begin
        if (dis_cmd) begin
          drv_d.ift    = IFT_NONE;
          drv_d.irq_en = 1'b0;
          drv_d.spkr   = 1'b0;
          state_d      = S_CFG_CLR;
        end else if (en_cmd) begin
          drv_d    = DRIVE_OFF;
          enab_d   = 1'b1;
          poll_d   = '0;
          tmr_load = 1'b1;
          tmr_us   = US_W'(T_OFF_US);
          state_d  = S_OFF_WAIT;
        end
      end

      S_OFF_WAIT: begin
        if (tmr_exp) begin
          drv_d.pwr = 1'b1;
          tmr_load  = 1'b1;
          tmr_us    = US_W'(T_ON_US);
          state_d   = S_PWR_WAIT;
        end
      end

      S_PWR_WAIT: begin
        if (tmr_exp) begin
          drv_d.oe  = 1'b1;
          drv_d.vpp = 1'b1;
          drv_d.rst = 1'b1;
          tmr_load  = 1'b1;
          tmr_us    = US_W'(T_RST_US);
          state_d   = S_RST_HOLD;
        end
      end

      S_RST_HOLD: begin
        if (tmr_exp) begin
          drv_d.rst = 1'b0;
          tmr_load  = 1'b1;
          tmr_us    = US_W'(T_SETTLE_US);
          state_d   = S_SETTLE;
        end
      end

      S_SETTLE: begin
        if (tmr_exp) begin
          state_d = S_POLL;
        end
      end

      S_POLL: begin
        if (cd_sense == 2'b00) begin
          abort_d = 1'b1;
          enab_d  = 1'b0;
          state_d = S_IDLE;
        end else if (card_ready) begin
          drv_d.ift    = card_is_io ? IFT_IO : IFT_MEM;
          drv_d.irq_en = card_is_io;
          drv_d.spkr   = card_is_io;
          done_d       = 1'b1;
          enab_d       = 1'b0;
          state_d      = S_READY;
        end else if (poll_q == POLL_LAST) begin
          tmo_d   = 1'b1;
          enab_d  = 1'b0;
          state_d = S_IDLE;
        end else begin
          poll_d   = poll_q + 1'b1;
          tmr_load = 1'b1;
          tmr_us   = US_W'(T_POLL_US);
          state_d  = S_POLL_WAIT;
        end
      end

      S_POLL_WAIT: begin
        if (tmr_exp) begin
          state_d = S_POLL;
        end
      end

      S_CFG_CLR: begin
        drv_d.pwr = 1'b0;
        drv_d.vpp = 1'b0;
        drv_d.oe  = 1'b0;
        drv_d.rst = 1'b0;
        tmr_load  = 1'b1;
        tmr_us    = US_W'(T_DOWN_US);
        state_d   = S_DOWN_WAIT;
      end

      S_DOWN_WAIT: begin
        if (tmr_exp) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end
      end

      default: begin
        state_d = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      drv         <= DRIVE_OFF;
      poll_q      <= '0;
      enabling    <= 1'b0;
      seq_done    <= 1'b0;
      seq_abort   <= 1'b0;
      seq_timeout <= 1'b0;
    end else begin
      state_q     <= state_d;
      drv         <= drv_d;
      poll_q      <= poll_d;
      enabling    <= enab_d;
      seq_done    <= done_d;
      seq_abort   <= abort_d;
      seq_timeout <= tmo_d;
    end
  end

endmodule

// File: rtl/socket_pwr_seq.sv
module socket_pwr_seq
  import sockseq_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int T_OFF_US    = 400000,
  parameter int T_ON_US     = 320000,
  parameter int T_RST_US    = 20,
  parameter int T_SETTLE_US = 20000,
  parameter int T_POLL_US   = 500,
  parameter int T_DOWN_US   = 300000,
  parameter int MAX_POLLS   = 10000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_cmd,
  input  logic       dis_cmd,
  input  logic [1:0] cd_sense,
  input  logic       card_ready,
  input  logic       card_is_io,
  output logic       main_pwr,
  output logic       vpp_on,
  output logic       if_oe,
  output logic       card_rst,
  output logic [1:0] if_type,
  output logic       io_irq_en,
  output logic       spkr_en,
  output logic       enabling,
  output logic       seq_done,
  output logic       seq_abort,
  output logic       seq_timeout
);

  localparam int CYC_PER_US = (CLK_FREQ_HZ / 1_000_000 < 1) ? 1 : CLK_FREQ_HZ / 1_000_000;
  localparam int US_SUM     = T_OFF_US + T_ON_US + T_RST_US + T_SETTLE_US + T_POLL_US + T_DOWN_US;
  localparam int US_W       = $clog2(US_SUM + 1);
  localparam int PC_W       = (MAX_POLLS < 2) ? 1 : $clog2(MAX_POLLS);

  logic            tmr_load;
  logic [US_W-1:0] tmr_us;
  logic            tmr_exp;
  sock_drive_t     drv;

  sockseq_timer #(
    .CYC_PER_US (CYC_PER_US),
    .US_W       (US_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_us (tmr_us),
    .expired (tmr_exp)
  );

  sockseq_ctrl #(
    .T_OFF_US    (T_OFF_US),
    .T_ON_US     (T_ON_US),
    .T_RST_US    (T_RST_US),
    .T_SETTLE_US (T_SETTLE_US),
    .T_POLL_US   (T_POLL_US),
    .T_DOWN_US   (T_DOWN_US),
    .MAX_POLLS   (MAX_POLLS),
    .US_W        (US_W),
    .PC_W        (PC_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .en_cmd      (en_cmd),
    .dis_cmd     (dis_cmd),
    .cd_sense    (cd_sense),
    .card_ready  (card_ready),
    .card_is_io  (card_is_io),
    .tmr_exp     (tmr_exp),
    .tmr_load    (tmr_load),
    .tmr_us      (tmr_us),
    .drv         (drv),
    .enabling    (enabling),
    .seq_done    (seq_done),
    .seq_abort   (seq_abort),
    .seq_timeout (seq_timeout)
  );

  assign main_pwr  = drv.pwr;
  assign vpp_on    = drv.vpp;
  assign if_oe     = drv.oe;
  assign card_rst  = drv.rst;
  assign if_type   = drv.ift;
  assign io_irq_en = drv.irq_en;
  assign spkr_en   = drv.spkr;

endmodule

// File: rtl/sockseq_checker.sv
module sockseq_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cd_sense,
  input logic       main_pwr,
  input logic       vpp_on,
  input logic       if_oe,
  input logic       card_rst,
  input logic [1:0] if_type,
  input logic       io_irq_en,
  input logic       enabling,
  input logic       seq_done,
  input logic       seq_abort,
  input logic       seq_timeout
);

  // R1: reset leaves the socket unpowered and idle
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!main_pwr && !vpp_on && !if_oe && !card_rst && if_type == 2'b00 && !enabling));

  // R4: reset pin only with all supplies up
  p_rst_supply_r4: assert property (@(posedge clk) disable iff (rst)
    card_rst |-> (main_pwr && vpp_on && if_oe));

  // R7: abort only after a poll that saw no card
  p_abort_no_card_r7: assert property (@(posedge clk) disable iff (rst)
    seq_abort |-> ($past(cd_sense) == 2'b00));

  // R8: I/O interrupt only on a powered I/O-configured socket
  p_io_cfg_r8: assert property (@(posedge clk) disable iff (rst)
    io_irq_en |-> (main_pwr && if_oe && if_type == 2'b10));

  // R9: one outcome at a time
  p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({seq_done, seq_abort, seq_timeout}));

  // R9: failed outcomes end the enabling phase
  p_end_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (seq_abort || seq_timeout) |-> !enabling);

  // R11: configuration is gone by the time power drops
  p_power_order_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(main_pwr) |-> (if_type == 2'b00 && !io_irq_en));

endmodule

bind socket_pwr_seq sockseq_checker u_sockseq_checker (
  .clk         (clk),
  .rst         (rst),
  .cd_sense    (cd_sense),
  .main_pwr    (main_pwr),
  .vpp_on      (vpp_on),
  .if_oe       (if_oe),
  .card_rst    (card_rst),
  .if_type     (if_type),
  .io_irq_en   (io_irq_en),
  .enabling    (enabling),
  .seq_done    (seq_done),
  .seq_abort   (seq_abort),
  .seq_timeout (seq_timeout)
);

// File: tb/socket_pwr_seq_bench.sv
`timescale 1ns/1ps
module socket_pwr_seq_bench;

  localparam int CYC       = 4;
  localparam int OFF_US    = 40;
  localparam int ON_US     = 32;
  localparam int RST_US    = 2;
  localparam int SET_US    = 10;
  localparam int POLL_US   = 5;
  localparam int DOWN_US   = 30;
  localparam int NPOLL     = 4;
  localparam int NOM_PWR   = OFF_US * CYC;
  localparam int NOM_RON   = (OFF_US + ON_US) * CYC;
  localparam int NOM_ROFF  = (OFF_US + ON_US + RST_US) * CYC;
  localparam int NOM_POLL0 = (OFF_US + ON_US + RST_US + SET_US) * CYC;
  localparam int NOM_DOWN  = DOWN_US * CYC;
  localparam int NEVER     = 9999;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_cmd = 1'b0, dis_cmd = 1'b0, card_ready = 1'b0, card_is_io = 1'b0;
  logic [1:0] cd_sense = 2'b11;
  logic main_pwr, vpp_on, if_oe, card_rst, io_irq_en, spkr_en;
  logic enabling, seq_done, seq_abort, seq_timeout;
  logic [1:0] if_type;

  always #2.5 clk = ~clk;

  socket_pwr_seq #(
    .CLK_FREQ_HZ (4_000_000),
    .T_OFF_US    (OFF_US),
    .T_ON_US     (ON_US),
    .T_RST_US    (RST_US),
    .T_SETTLE_US (SET_US),
    .T_POLL_US   (POLL_US),
    .T_DOWN_US   (DOWN_US),
    .MAX_POLLS   (NPOLL)
  ) u_socket_pwr_seq (
    .clk, .rst, .en_cmd, .dis_cmd, .cd_sense, .card_ready, .card_is_io,
    .main_pwr, .vpp_on, .if_oe, .card_rst, .if_type, .io_irq_en, .spkr_en,
    .enabling, .seq_done, .seq_abort, .seq_timeout
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // outcome codes: 0 done, 1 abort, 2 timeout
  typedef struct packed {
    logic       io;
    logic [1:0] cd;
    int         rdy;
    int         outc;
    int         k;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{io: 1'b1, cd: 2'b11, rdy: 0,     outc: 0, k: 0},
    '{io: 1'b0, cd: 2'b11, rdy: 350,   outc: 0, k: 1},
    '{io: 1'b1, cd: 2'b10, rdy: 372,   outc: 0, k: 2},
    '{io: 1'b0, cd: 2'b00, rdy: 0,     outc: 1, k: 0},
    '{io: 1'b1, cd: 2'b11, rdy: NEVER, outc: 2, k: NPOLL - 1}
  };

  int t_pwr, t_ron, t_roff, t_end, outcome;
  int pwr_t1, ift_t1, enab_t1, enab_mid, pwr_lost;

  task automatic run_enable(input logic io, input logic [1:0] cd, input int rdy_t,
                            input int inj_en, input int inj_dis);
    @(negedge clk);
    card_is_io = io; cd_sense = cd; card_ready = (rdy_t == 0); en_cmd = 1'b1;
    t_pwr = -1; t_ron = -1; t_roff = -1; t_end = -1; outcome = -1;
    pwr_lost = 0; enab_mid = -1; pwr_t1 = -1; ift_t1 = -1; enab_t1 = -1;
    for (int t = 1; t <= 2000 && outcome < 0; t++) begin
      @(negedge clk);
      en_cmd = 1'b0; dis_cmd = 1'b0;
      if (t == rdy_t) card_ready = 1'b1;
      if (t == inj_en) en_cmd = 1'b1;
      if (t == inj_dis) dis_cmd = 1'b1;
      if (t == 1) begin pwr_t1 = int'(main_pwr); ift_t1 = int'(if_type); enab_t1 = int'(enabling); end
      if (t == 100) enab_mid = int'(enabling);
      if (main_pwr && t_pwr < 0) t_pwr = t;
      if (t_pwr >= 0 && !main_pwr) pwr_lost = 1;
      if (card_rst && t_ron < 0) t_ron = t;
      if (!card_rst && t_ron >= 0 && t_roff < 0) t_roff = t;
      if (seq_done) begin outcome = 0; t_end = t; end
      else if (seq_abort) begin outcome = 1; t_end = t; end
      else if (seq_timeout) begin outcome = 2; t_end = t; end
    end
    en_cmd = 1'b0; dis_cmd = 1'b0;
  endtask

  int d_cfg_ok, d_pwr1, d_pwr2, d_end, d_enab;

  task automatic run_disable(input int inj_en);
    @(negedge clk);
    dis_cmd = 1'b1;
    d_end = -1; d_cfg_ok = 0; d_pwr1 = -1; d_pwr2 = -1; d_enab = 0;
    for (int t = 1; t <= 1000 && d_end < 0; t++) begin
      @(negedge clk);
      dis_cmd = 1'b0; en_cmd = 1'b0;
      if (t == inj_en) en_cmd = 1'b1;
      if (t == 1) begin
        d_cfg_ok = int'(if_type == 2'b00 && !io_irq_en && !spkr_en);
        d_pwr1 = int'(main_pwr);
      end
      if (t == 2) d_pwr2 = int'(main_pwr || vpp_on || if_oe || card_rst);
      if (enabling) d_enab = 1;
      if (seq_done) d_end = t;
    end
    en_cmd = 1'b0;
  endtask

  function automatic int hi_lim(input int nom, input int phases);
    return nom + 2 * phases;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: state during and right after reset
    chk(!main_pwr && !vpp_on && !if_oe && !card_rst, "R1", "supplies in reset",
        int'({main_pwr, vpp_on, if_oe, card_rst}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(if_type == 2'b00 && !io_irq_en && !spkr_en && !enabling, "R1", "config after reset",
        int'({if_type, io_irq_en, spkr_en, enabling}), 0);
    chk(!seq_done && !seq_abort && !seq_timeout, "R1", "no pulse after reset",
        int'({seq_done, seq_abort, seq_timeout}), 0);

    foreach (VECS[i]) begin
      int nom_end;
      int exp_ift;
      run_enable(VECS[i].io, VECS[i].cd, VECS[i].rdy, 0, 0);
      nom_end = NOM_POLL0 + VECS[i].k * POLL_US * CYC;
      chk(enab_t1 == 1 && pwr_t1 == 0, "R2", "enabling up, power off", enab_t1, 1);
      chk(enab_mid == 1, "R9", "enabling mid-sequence", enab_mid, 1);
      chk(t_pwr >= NOM_PWR && t_pwr <= hi_lim(NOM_PWR, 1), "R3", "power-on time", t_pwr, NOM_PWR);
      chk(t_ron >= NOM_RON && t_ron <= hi_lim(NOM_RON, 2), "R4", "reset assert time", t_ron, NOM_RON);
      chk(t_roff >= NOM_ROFF && t_roff <= hi_lim(NOM_ROFF, 3), "R4", "reset release time", t_roff, NOM_ROFF);
      chk(outcome == VECS[i].outc, (VECS[i].outc == 0) ? "R5" : (VECS[i].outc == 1) ? "R7" : "R6",
          "outcome", outcome, VECS[i].outc);
      chk(t_end >= nom_end && t_end <= hi_lim(nom_end, 5 + 2 * VECS[i].k), "R13",
          "outcome time", t_end, nom_end);
      chk(!enabling, "R9", "enabling after outcome", int'(enabling), 0);
      exp_ift = (VECS[i].outc != 0) ? 0 : (VECS[i].io ? 2 : 1);
      chk(int'(if_type) == exp_ift, "R8", "interface type", int'(if_type), exp_ift);
      chk(io_irq_en == (VECS[i].outc == 0 && VECS[i].io) && spkr_en == io_irq_en, "R8",
          "irq/speaker", int'({io_irq_en, spkr_en}),
          (VECS[i].outc == 0 && VECS[i].io) ? 3 : 0);
      chk(main_pwr && if_oe && vpp_on, "R6", "supplies stay on at end",
          int'({main_pwr, if_oe, vpp_on}), 7);
      run_disable(0);
      chk(d_cfg_ok == 1 && d_pwr1 == 1, "R11", "config cleared with power still on",
          d_cfg_ok * 2 + d_pwr1, 3);
      chk(d_pwr2 == 0, "R11", "power removed one cycle later", d_pwr2, 0);
      chk(d_end >= NOM_DOWN && d_end <= hi_lim(NOM_DOWN, 2), "R11", "power-down time", d_end, NOM_DOWN);
    end

    // R2 and R10: restart from a configured socket, stray commands mid-run
    run_enable(1'b1, 2'b11, 0, 0, 0);
    chk(outcome == 0 && if_type == 2'b10, "R8", "configured before restart", int'(if_type), 2);
    run_enable(1'b0, 2'b00, 0, 200, 250);
    chk(pwr_t1 == 0 && ift_t1 == 0, "R2", "restart clears power and config", pwr_t1 * 4 + ift_t1, 0);
    chk(pwr_lost == 0, "R10", "stop command ignored while enabling", pwr_lost, 0);
    chk(outcome == 1 && t_end >= NOM_POLL0 && t_end <= hi_lim(NOM_POLL0, 5), "R10",
        "repeated start does not restart", t_end, NOM_POLL0);

    // R10: start command during power-down
    run_disable(50);
    chk(d_enab == 0, "R10", "start ignored during power-down", d_enab, 0);
    chk(d_end >= NOM_DOWN && d_end <= hi_lim(NOM_DOWN, 2), "R10", "power-down time kept", d_end, NOM_DOWN);
    @(negedge clk);
    chk(!main_pwr && !enabling, "R10", "socket stays off", int'({main_pwr, enabling}), 0);

    // R12: both commands together while idle
    @(negedge clk);
    en_cmd = 1'b1; dis_cmd = 1'b1;
    @(negedge clk);
    en_cmd = 1'b0; dis_cmd = 1'b0;
    chk(!enabling && !main_pwr, "R12", "stop wins over start", int'({enabling, main_pwr}), 0);
    d_end = -1;
    for (int t = 2; t <= 400 && d_end < 0; t++) begin
      @(negedge clk);
      if (seq_done) d_end = t;
    end
    chk(d_end >= NOM_DOWN && d_end <= hi_lim(NOM_DOWN, 2), "R12", "power-down ran", d_end, NOM_DOWN);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule